// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes an 8-bit processor from an instruction boundary into an interrupt service routine. When a non-maskable or maskable request is present at a boundary, the block runs the bus cycles of the entry sequence. These are an interrupt-acknowledge cycle or an opcode-fetch-style cycle, a refresh phase, two stack writes that save the program counter and, in table mode, two table reads. At the end it reports the program counter and stack pointer the core must adopt. The core keeps its register file, enable flip-flops and instruction decoder. The block takes snapshots of PC, SP, the page register and the mode at acceptance, and it returns results on a single-cycle completion pulse.

Time is counted in half-cycles: one clock of this block equals one half-cycle of the processor bus. Each bus phase has a start part, an optional wait part and an end part. The start part ends with a look at the wait input, and every wait sample that is high adds two clocks. Mode 0 does not vector; it hands the acknowledge byte back to the core as an opcode. Mode 1 jumps to a fixed address. Modes 2 and 3 build a table pointer from the page register and the acknowledge byte. A non-maskable request jumps to its own fixed address.

Top module: `irq_vector_seq`

## Requirements
- R1: While `rstN` is low, and for 6 clocks after it rises, `busy` is 1 and `busOp` reads 1 (internal). In the next clock `done` is 1, `pcOut` is 0x0000 and `spOut` is 0xFFFF.
- R2: A request is accepted only when the block is idle and `atBoundary` is 1 at a clock edge. Requests without a boundary, or while `busy` is 1, leave `busOp` at 0 (idle) and leave the running sequence unchanged.
- R3: If `nmiReq` and `irqReq` are both 1 at acceptance, the non-maskable sequence runs, and its first busy clock shows `busOp` 3 (opcode fetch).
- R4: In modes 1, 2 and 3, with no waits, the sequence is: acknowledge (`busOp` 2) for 7+3 clocks, refresh (`busOp` 4) for 4 clocks, then the two stack writes. Mode 1 is busy 26 clocks and ends with `pcOut` = 0x0038.
- R5: `waitIn` is sampled on the last clock of the start part of the acknowledge, fetch, read and write phases, and on the last clock of each 2-clock wait part. Each high sample adds 2 clocks with `busOp` and `addrOut` unchanged. Start/end lengths are: acknowledge 5/3 (mode 0) or 7/3, fetch 3/1, read and write 3/3.
- R6: The PC is saved high byte first. `busOp` 6 (write) runs with `addrOut` = SP-1 and `dataOut` = PC[15:8], then with SP-2 and PC[7:0], with 16-bit wrap. `spOut` = SP-2 for every vectoring sequence.
- R7: In modes 2 and 3 the pointer is {page, acknowledge byte}. A read (`busOp` 5) at the pointer supplies PC[7:0] and a read at pointer+1 supplies PC[15:8].
- R8: In mode 0, after an acknowledge of 5+3 clocks, `done` rises with `opcodeValid` = 1 and `opcodeOut` = the acknowledge byte. There is no refresh, write or read phase, and `pcOut`/`spOut` equal the PC/SP given at acceptance.
- R9: A non-maskable entry runs fetch (`busOp` 3, `addrOut` = PC) for 3+1 clocks, refresh for 6 clocks and the two stack writes, then ends with `pcOut` = 0x0066.
- R10: `done` is a one-clock pulse in the clock after the last busy clock, with `busy` = 0. A byte read on the bus is taken from `dataIn` on the last clock of its phase. `pcOut`/`spOut` hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiReq | input | 1 | Non-maskable request |
| irqReq | input | 1 | Maskable request |
| atBoundary | input | 1 | Core is at an instruction boundary |
| intMode | input | 2 | Maskable mode: 0 opcode, 1 fixed, 2/3 table |
| pcIn | input | 16 | Program counter to save |
| spIn | input | 16 | Stack pointer before entry |
| iReg | input | 8 | Table page register |
| waitIn | input | 1 | Bus wait request, high inserts wait |
| dataIn | input | 8 | Data bus input |
| busy | output | 1 | Sequence in progress |
| busOp | output | 3 | 0 idle, 1 internal, 2 ack, 3 fetch, 4 refresh, 5 read, 6 write |
| addrOut | output | 16 | Bus address for fetch, read, write |
| dataOut | output | 8 | Write data |
| pcOut | output | 16 | New program counter |
| spOut | output | 16 | New stack pointer |
| done | output | 1 | Completion pulse |
| opcodeOut | output | 8 | Mode 0 opcode to decode |
| opcodeValid | output | 1 | `opcodeOut` is valid with `done` |

## Verification
The acknowledge or fetch phase shows in the first clock after the accepting edge. With no waits, `done` follows 8 clocks after acceptance in mode 0, 22 in non-maskable entry, 26 in mode 1 and 38 in table mode. Each high wait sample shifts everything after it by exactly 2 clocks. The bench turns each scenario into a clock-by-clock list of expected bus state, with the wait and data inputs to drive in each clock. Outputs are compared half a period after each edge, so every result is checked in the exact clock in which it is due and never in a nearby one.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    BUS_IDLE     = 3'd0,
    BUS_INTERNAL = 3'd1,
    BUS_INTACK   = 3'd2,
    BUS_FETCH    = 3'd3,
    BUS_REFRESH  = 3'd4,
    BUS_READ     = 3'd5,
    BUS_WRITE    = 3'd6
  } busOpE;

  typedef enum logic [2:0] {
    ADR_NONE, ADR_PC, ADR_SP1, ADR_SP2, ADR_PTR, ADR_PTR1
  } addrSelE;

  typedef enum logic [2:0] {
    PC_RESET, PC_KEEP, PC_NMI, PC_FIXED, PC_TABLE
  } pcSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;
    logic  capAck;
    logic  capLo;
    logic  finish;
    pcSelE pcSel;
  } strobeT;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ACK0_START  = 5,
  parameter int ACK_START   = 7,
  parameter int ACK_END     = 3,
  parameter int FETCH_START = 3,
  parameter int FETCH_END   = 1,
  parameter int REFRESH_IRQ = 4,
  parameter int REFRESH_NMI = 6,
  parameter int MEM_START   = 3,
  parameter int MEM_END     = 3,
  parameter int RESET_LEN   = 6,
  parameter int WAIT_LEN    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nmiReq,
  input  logic       irqReq,
  input  logic       atBoundary,
  input  logic [1:0] intMode,
  input  logic       waitIn,
  output logic       busy,
  output busOpE      busOp,
  output addrSelE    addrSel,
  output strobeT     strobe
);

  localparam int MAX_A   = maxOf(maxOf(ACK0_START, ACK_START), maxOf(ACK_END, FETCH_START));
  localparam int MAX_B   = maxOf(maxOf(REFRESH_IRQ, REFRESH_NMI), maxOf(MEM_START, MEM_END));
  localparam int MAX_C   = maxOf(maxOf(RESET_LEN, WAIT_LEN), FETCH_END);
  localparam int MAX_LEN = maxOf(maxOf(MAX_A, MAX_B), MAX_C);
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RESET, ST_ACK, ST_FETCH, ST_REFR,
    ST_PUSHHI, ST_PUSHLO, ST_VECLO, ST_VECHI
  } stepE;

  typedef enum logic [1:0] {PH_START, PH_WAIT, PH_END} phaseE;

  stepE             step;
  stepE             nxtStep;
  phaseE            phase;
  logic [CNT_W-1:0] cnt;
  logic             kindNmi;
  logic [1:0]       modeL;
  logic             finalStep;
  pcSelE            pcSel;
  logic             cntZero;
  logic             lastCycle;
  logic             accept;
  int               curEnd;
  int               entryLen;

  function automatic int startLenOf(stepE s, logic [1:0] m, logic n);
    case (s)
      ST_RESET: return RESET_LEN;
      ST_ACK:   return (m == 2'd0) ? ACK0_START : ACK_START;
      ST_FETCH: return FETCH_START;
      ST_REFR:  return n ? REFRESH_NMI : REFRESH_IRQ;
      default:  return MEM_START;
    endcase
  endfunction

  function automatic int endLenOf(stepE s);
    case (s)
      ST_ACK:                                   return ACK_END;
      ST_FETCH:                                 return FETCH_END;
      ST_PUSHHI, ST_PUSHLO, ST_VECLO, ST_VECHI: return MEM_END;
      default:                                  return 0;
    endcase
  endfunction

  // step ordering per entry kind
  always_comb begin
    finalStep = 1'b0;
    pcSel     = PC_KEEP;
    nxtStep   = ST_IDLE;
    case (step)
      ST_RESET: begin finalStep = 1'b1; pcSel = PC_RESET; end
      ST_ACK: begin
        if (modeL == 2'd0) begin finalStep = 1'b1; pcSel = PC_KEEP; end
        else nxtStep = ST_REFR;
      end
      ST_FETCH:  nxtStep = ST_REFR;
      ST_REFR:   nxtStep = ST_PUSHHI;
      ST_PUSHHI: nxtStep = ST_PUSHLO;
      ST_PUSHLO: begin
        if (kindNmi) begin finalStep = 1'b1; pcSel = PC_NMI; end
        else if (modeL == 2'd1) begin finalStep = 1'b1; pcSel = PC_FIXED; end
        else nxtStep = ST_VECLO;
      end
      ST_VECLO: nxtStep = ST_VECHI;
      ST_VECHI: begin finalStep = 1'b1; pcSel = PC_TABLE; end
      default: ;
    endcase
  end

  assign curEnd    = endLenOf(step);
  assign cntZero   = (cnt == '0);
  assign lastCycle = (step != ST_IDLE) && cntZero &&
                     ((phase == PH_END) || (phase == PH_START && curEnd == 0));
  assign accept    = (step == ST_IDLE) && atBoundary && (nmiReq || irqReq);
  assign entryLen  = nmiReq ? FETCH_START : ((intMode == 2'd0) ? ACK0_START : ACK_START);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step    <= ST_RESET;
      phase   <= PH_START;
      cnt     <= CNT_W'(RESET_LEN - 1);
      kindNmi <= 1'b0;
      modeL   <= 2'd0;
    end else if (step == ST_IDLE) begin
      if (accept) begin
        kindNmi <= nmiReq;
        modeL   <= intMode;
        step    <= nmiReq ? ST_FETCH : ST_ACK;
        phase   <= PH_START;
        cnt     <= CNT_W'(entryLen - 1);
      end
    end else if (!cntZero) begin
      cnt <= cnt - 1'b1;
    end else if (lastCycle) begin
      if (finalStep) begin
        step <= ST_IDLE;
      end else begin
        step  <= nxtStep;
        phase <= PH_START;
        cnt   <= CNT_W'(startLenOf(nxtStep, modeL, kindNmi) - 1);
      end
    end else if (waitIn) begin
      phase <= PH_WAIT;
      cnt   <= CNT_W'(WAIT_LEN - 1);
    end else begin
      phase <= PH_END;
      cnt   <= CNT_W'(curEnd - 1);
    end
  end

  always_comb begin
    busOp   = BUS_IDLE;
    addrSel = ADR_NONE;
    case (step)
      ST_RESET:  busOp = BUS_INTERNAL;
      ST_ACK:    busOp = BUS_INTACK;
      ST_FETCH:  begin busOp = BUS_FETCH;   addrSel = ADR_PC;   end
      ST_REFR:   busOp = BUS_REFRESH;
      ST_PUSHHI: begin busOp = BUS_WRITE;   addrSel = ADR_SP1;  end
      ST_PUSHLO: begin busOp = BUS_WRITE;   addrSel = ADR_SP2;  end
      ST_VECLO:  begin busOp = BUS_READ;    addrSel = ADR_PTR;  end
      ST_VECHI:  begin busOp = BUS_READ;    addrSel = ADR_PTR1; end
      default: ;
    endcase
  end

  assign busy          = (step != ST_IDLE);
  assign strobe.load   = accept;
  assign strobe.capAck = lastCycle && (step == ST_ACK);
  assign strobe.capLo  = lastCycle && (step == ST_VECLO);
  assign strobe.finish = lastCycle && finalStep;
  assign strobe.pcSel  = pcSel;

  // R2: no boundary keeps the block idle
  a_r2_needs_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_IDLE && !atBoundary) |=> (step == ST_IDLE));

  // R3: non-maskable wins at acceptance
  a_r3_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_IDLE && atBoundary && nmiReq) |=> (step == ST_FETCH));

  // R5: a high wait sample at the end of a wait part repeats it
  a_r5_wait_repeats: assert property (@(posedge clk) disable iff (!rstN)
    (step != ST_IDLE && phase == PH_WAIT && cntZero && waitIn) |=> (phase == PH_WAIT));

  // R6: low-byte write only follows the high-byte write
  a_r6_push_order: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_PUSHLO && $past(step) != ST_PUSHLO) |-> ($past(step) == ST_PUSHHI));

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] NMI_VEC   = 16'h0066,
  parameter logic [15:0] FIXED_VEC = 16'h0038,
  parameter logic [15:0] SP_RESET  = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] iReg,
  input  logic [DATA_W-1:0] dataIn,
  input  addrSelE           addrSel,
  input  strobeT            strobe,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              done,
  output logic [DATA_W-1:0] opcodeOut,
  output logic              opcodeValid
);

  localparam int PTR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] ctxPc;
  logic [ADDR_W-1:0] ctxSp;
  logic [DATA_W-1:0] ctxI;
  logic [DATA_W-1:0] ackByte;
  logic [DATA_W-1:0] vecLo;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] newPc;
  logic [ADDR_W-1:0] newSp;

  assign ptr = ADDR_W'({ctxI, ackByte});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctxPc   <= '0;
      ctxSp   <= '0;
      ctxI    <= '0;
      ackByte <= '0;
      vecLo   <= '0;
    end else begin
      if (strobe.load) begin
        ctxPc <= pcIn;
        ctxSp <= spIn;
        ctxI  <= iReg;
      end
      if (strobe.capAck) ackByte <= dataIn;
      if (strobe.capLo)  vecLo   <= dataIn;
    end
  end

  always_comb begin
    case (strobe.pcSel)
      PC_RESET: newPc = '0;
      PC_NMI:   newPc = ADDR_W'(NMI_VEC);
      PC_FIXED: newPc = ADDR_W'(FIXED_VEC);
      PC_TABLE: newPc = ADDR_W'({dataIn, vecLo});
      default:  newPc = ctxPc;
    endcase
    case (strobe.pcSel)
      PC_RESET: newSp = ADDR_W'(SP_RESET);
      PC_KEEP:  newSp = ctxSp;
      default:  newSp = ctxSp - ADDR_W'(2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcOut       <= '0;
      spOut       <= '0;
      done        <= 1'b0;
      opcodeOut   <= '0;
      opcodeValid <= 1'b0;
    end else begin
      done        <= strobe.finish;
      opcodeValid <= strobe.finish && (strobe.pcSel == PC_KEEP);
      if (strobe.finish) begin
        pcOut <= newPc;
        spOut <= newSp;
        if (strobe.pcSel == PC_KEEP) opcodeOut <= dataIn;
      end
    end
  end

  always_comb begin
    addrOut = '0;
    dataOut = '0;
    case (addrSel)
      ADR_PC:   addrOut = ctxPc;
      ADR_SP1:  begin addrOut = ctxSp - ADDR_W'(1); dataOut = ctxPc[ADDR_W-1 -: DATA_W]; end
      ADR_SP2:  begin addrOut = ctxSp - ADDR_W'(2); dataOut = ctxPc[DATA_W-1:0]; end
      ADR_PTR:  addrOut = ptr;
      ADR_PTR1: addrOut = ptr + ADDR_W'(1);
      default: ;
    endcase
  end

  // R8: opcode hand-off only appears together with completion
  a_r8_opcode_with_done: assert property (@(posedge clk) disable iff (!rstN)
    opcodeValid |-> (done && PTR_W == ADDR_W));

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReq,
  input  logic              irqReq,
  input  logic              atBoundary,
  input  logic [1:0]        intMode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] iReg,
  input  logic              waitIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              busy,
  output logic [2:0]        busOp,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              done,
  output logic [DATA_W-1:0] opcodeOut,
  output logic              opcodeValid
);

  busOpE   busOpS;
  addrSelE addrSel;
  strobeT  strobe;

  irq_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .irqReq(irqReq),
    .atBoundary(atBoundary), .intMode(intMode), .waitIn(waitIn),
    .busy(busy), .busOp(busOpS), .addrSel(addrSel), .strobe(strobe)
  );

  irq_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .spIn(spIn), .iReg(iReg),
    .dataIn(dataIn), .addrSel(addrSel), .strobe(strobe),
    .addrOut(addrOut), .dataOut(dataOut), .pcOut(pcOut), .spOut(spOut),
    .done(done), .opcodeOut(opcodeOut), .opcodeValid(opcodeValid)
  );

  assign busOp = busOpS;

  // R10: completion is reported only once the sequencer is idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10: completion is a single-clock pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/test_irq_vector_seq.sv
module test_irq_vector_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        nmiReq = 1'b0, irqReq = 1'b0, atBoundary = 1'b0;
  logic [1:0]  intMode = 2'd0;
  logic [15:0] pcIn = '0, spIn = '0;
  logic [7:0]  iReg = '0;
  logic        waitIn = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        busy, done, opcodeValid;
  logic [2:0]  busOp;
  logic [15:0] addrOut, pcOut, spOut;
  logic [7:0]  dataOut, opcodeOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_vector_seq i_irq_vector_seq (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .irqReq(irqReq),
    .atBoundary(atBoundary), .intMode(intMode), .pcIn(pcIn), .spIn(spIn),
    .iReg(iReg), .waitIn(waitIn), .dataIn(dataIn), .busy(busy),
    .busOp(busOp), .addrOut(addrOut), .dataOut(dataOut), .pcOut(pcOut),
    .spOut(spOut), .done(done), .opcodeOut(opcodeOut), .opcodeValid(opcodeValid)
  );

  // one expected clock: outputs to see, inputs to drive
  typedef struct packed {
    logic        busy;
    logic [2:0]  op;
    logic [15:0] addr;
    logic [7:0]  wdat;
    logic        wD;
    logic [7:0]  dD;
    logic        nmi;
    logic        irq;
    logic        bnd;
    logic        done;
    logic [15:0] pc;
    logic [15:0] sp;
    logic        opv;
    logic [7:0]  opc;
    logic [7:0]  req;
  } entT;

  entT q[$];
  logic hNmi = 1'b0, hIrq = 1'b0, hBnd = 1'b0;
  bit   released = 1'b0;

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic addE(input bit b, input int op, input int addr, input int wdat,
                      input bit wD, input int dD, input int req);
    entT e;
    e = '0;
    e.busy = b; e.op = op[2:0]; e.addr = addr[15:0]; e.wdat = wdat[7:0];
    e.wD = wD; e.dD = dD[7:0]; e.nmi = hNmi; e.irq = hIrq; e.bnd = hBnd;
    e.req = req[7:0];
    q.push_back(e);
  endtask

  task automatic addPhase(input int op, input int addr, input int wdat, input int sLen,
                          input int eLen, input int waits, input int dD, input int req);
    for (int i = 0; i < sLen; i++) addE(1, op, addr, wdat, (i == sLen - 1) && (waits > 0), dD, req);
    for (int w = 0; w < waits; w++)
      for (int j = 0; j < 2; j++) addE(1, op, addr, wdat, (j == 1) && (w < waits - 1), dD, req);
    for (int i = 0; i < eLen; i++) addE(1, op, addr, wdat, 0, dD, req);
  endtask

  task automatic addDone(input int pc, input int sp, input bit opv, input int opc, input int req);
    entT e;
    hNmi = 0; hIrq = 0; hBnd = 0;
    e = '0;
    e.done = 1; e.pc = pc[15:0]; e.sp = sp[15:0]; e.opv = opv; e.opc = opc[7:0];
    e.req = req[7:0];
    q.push_back(e);
  endtask

  task automatic runQ();
    entT e;
    while (q.size() > 0) begin
      @(negedge clk);
      if (!released) begin rstN = 1'b1; released = 1'b1; end
      e = q.pop_front();
      chk(e.req, "busy", busy, e.busy);
      chk(e.req, "busOp", busOp, e.op);
      chk(e.req, "addrOut", addrOut, e.addr);
      chk(e.req, "dataOut", dataOut, e.wdat);
      chk(10, "done", done, e.done);
      if (e.done) begin
        chk(e.req, "pcOut", pcOut, e.pc);
        chk(e.req, "spOut", spOut, e.sp);
        chk(e.req, "opcodeValid", opcodeValid, e.opv);
        if (e.opv) chk(e.req, "opcodeOut", opcodeOut, e.opc);
      end else begin
        chk(8, "opcodeValid", opcodeValid, 0);
      end
      nmiReq = e.nmi; irqReq = e.irq; atBoundary = e.bnd;
      waitIn = e.wD; dataIn = e.dD;
    end
  endtask

  // maskable entry: mode, context, bus bytes, wait counts
  task automatic scnIrq(input int mode, input int pc, input int sp, input int iv,
                        input int ack, input int lo, input int hi, input int wAck,
                        input int wMem, input bit nmiDuring, input int req);
    int ptr;
    intMode = mode[1:0]; pcIn = pc[15:0]; spIn = sp[15:0]; iReg = iv[7:0];
    hNmi = 0; hIrq = 1; hBnd = 1;
    addE(0, 0, 0, 0, 0, 0, 2);
    hNmi = nmiDuring;                       // R2: ignored while busy
    if (mode == 0) begin
      addPhase(2, 0, 0, 5, 3, wAck, ack, 8);  // R8
      addDone(pc, sp, 1, ack, 8);
    end else begin
      addPhase(2, 0, 0, 7, 3, wAck, ack, req); // R4 acknowledge
      addPhase(4, 0, 0, 4, 0, 0, 0, 4);        // R4 refresh
      addPhase(6, (sp - 1) & 16'hFFFF, (pc >> 8) & 8'hFF, 3, 3, wMem, 0, 6); // R6
      addPhase(6, (sp - 2) & 16'hFFFF, pc & 8'hFF, 3, 3, wMem, 0, 6);
      if (mode >= 2) begin
        ptr = ((iv & 8'hFF) << 8) | (ack & 8'hFF);                      // R7
        addPhase(5, ptr, 0, 3, 3, wMem, lo, 7);
        addPhase(5, (ptr + 1) & 16'hFFFF, 0, 3, 3, wMem, hi, 7);
        addDone(((hi & 8'hFF) << 8) | (lo & 8'hFF), (sp - 2) & 16'hFFFF, 0, 0, 7);
      end else begin
        addDone(16'h0038, (sp - 2) & 16'hFFFF, 0, 0, 4);
      end
    end
    runQ();
  endtask

  task automatic scnNmi(input int pc, input int sp, input int wF, input bit alsoIrq);
    pcIn = pc[15:0]; spIn = sp[15:0]; intMode = 2'd1;
    hNmi = 1; hIrq = alsoIrq; hBnd = 1;
    addE(0, 0, 0, 0, 0, 0, 3);
    addPhase(3, pc, 0, 3, 1, wF, 0, 3);    // R3 / R9 fetch
    addPhase(4, 0, 0, 6, 0, 0, 0, 9);      // R9 refresh
    addPhase(6, (sp - 1) & 16'hFFFF, (pc >> 8) & 8'hFF, 3, 3, 0, 0, 6);
    addPhase(6, (sp - 2) & 16'hFFFF, pc & 8'hFF, 3, 3, 0, 0, 6);
    addDone(16'h0066, (sp - 2) & 16'hFFFF, 0, 0, 9);
    runQ();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1 rstN = 1'b0;
    @(negedge clk);
    // R1: state held in reset
    chk(1, "busy in reset", busy, 1);
    chk(1, "busOp in reset", busOp, 1);
    @(negedge clk);
    // R1: six internal clocks after release, then reset result
    addPhase(1, 0, 0, 6, 0, 0, 0, 1);
    addDone(16'h0000, 16'hFFFF, 0, 0, 1);
    runQ();
    // R2: request without a boundary stays idle
    hNmi = 0; hIrq = 1; hBnd = 0;
    for (int i = 0; i < 4; i++) addE(0, 0, 0, 0, 0, 0, 2);
    hNmi = 1;
    for (int i = 0; i < 3; i++) addE(0, 0, 0, 0, 0, 0, 2);
    hNmi = 0; hIrq = 0;
    addE(0, 0, 0, 0, 0, 0, 2);
    runQ();
    // R4, R6, R2: fixed vector, no waits, NMI raised mid-sequence
    scnIrq(1, 16'h1234, 16'h8000, 8'h00, 8'hFF, 0, 0, 0, 0, 1, 4);
    // R5: waits on acknowledge and on writes
    scnIrq(1, 16'hA55A, 16'h4001, 8'h00, 8'h00, 0, 0, 2, 1, 0, 5);
    // R7: table mode via code 2
    scnIrq(2, 16'h0F0E, 16'hC000, 8'h3A, 8'h5C, 8'hEF, 8'hBE, 0, 0, 0, 7);
    // R7, R5: table mode via code 3, pointer crossing a page, waits on reads
    scnIrq(3, 16'h8001, 16'h0100, 8'h12, 8'hFF, 8'h34, 8'h56, 1, 2, 0, 7);
    // R8: opcode mode with one wait
    scnIrq(0, 16'h2222, 16'h3333, 8'h44, 8'hC7, 0, 0, 1, 0, 0, 8);
    // R3, R9: NMI with a maskable request also present, stack wrap at SP=1
    scnNmi(16'hBEEF, 16'h0001, 0, 1);
    // R9, R5: NMI with a fetch wait, SP=0 wrap
    scnNmi(16'h0100, 16'h0000, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule